// File: doc/BRIEF.md
# Multi-channel ADC readout multiplexer

This block gathers the 18-bit results of eight analog-to-digital converters into a single image data FIFO and presents them, 16 bits at a time, on a backplane data bus shared with other boards. A rising edge on the transfer request starts a capture. The mode input decides what is captured. At 0, all eight results are queued in channel order. At 1, one result is queued, picked by the low three bits of the backplane address. Tying the mode input high gives the usual single-channel operation.

The bus address is seven bits wide. Its upper four bits must equal the board jumper value before this board drives the bus or consumes a FIFO entry. A low-select option chooses which 16 of the 18 stored bits reach the bus. The FIFO is sixteen entries deep and keeps full 18-bit samples. It has sticky flags for a read from an empty FIFO and for a write into a full one, and a clear pulse that empties it.

Top module: `adc_readout_mux`

## Requirements
- R1: With the mode input at 0, a rising edge of the transfer request snapshots all eight results. Starting the next cycle, it writes them one per cycle in the order channel 0, 1, ... 7. Holding the request high produces no further writes.
- R2: With the mode input at 1, a rising edge of the transfer request writes exactly one entry: the result of the channel given by address bits [2:0] at that edge.
- R3: The bus output enable is high exactly when address bits [6:3] equal the board jumper value. Address bits [2:0] play no part in this match. While the enable is low, the bus data is zero and a read request does not remove an entry.
- R4: With low-select at 0, the bus carries bits [17:2] of the FIFO head. With low-select at 1, it carries bits [15:0].
- R5: An addressed read of an empty FIFO returns zero and sets the underflow flag. The flag stays set until a clear or a reset.
- R6: A write into a full FIFO is dropped and sets the overflow flag, which stays set until a clear or a reset. A write in the same cycle as an addressed read of a full FIFO is accepted and does not set the flag.
- R7: A clear pulse empties the FIFO, clears both flags and abandons any transfer in progress. It takes precedence over a read or write in the same cycle.
- R8: After reset the FIFO is empty, both flags are low and no transfer is in progress.
- R9: The FIFO holds sixteen entries. They are read back in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data_i | input | 144 | Eight 18-bit conversion results, channel 0 in the low bits |
| xfer_i | input | 1 | Transfer request; its rising edge starts a capture |
| single_mode_i | input | 1 | 1: single-channel capture, 0: all-channels capture |
| low_sel_i | input | 1 | 1: bus carries bits [15:0], 0: bits [17:2] |
| fifo_clr_i | input | 1 | Empties the FIFO and clears the flags |
| bus_addr_i | input | 7 | Backplane address: [6:3] board, [2:0] channel |
| board_id_i | input | 4 | Board jumper value |
| bus_rd_i | input | 1 | Read strobe; removes one entry when this board is addressed |
| bus_data_o | output | 16 | Windowed FIFO head, zero when not addressed or empty |
| bus_oe_o | output | 1 | Bus drive enable (board addressed) |
| overflow_o | output | 1 | Sticky: a write was dropped |
| underflow_o | output | 1 | Sticky: an empty FIFO was read |

## Verification
A FIFO write from the transfer sequencer and an addressed pop from the bus can land in the same cycle. This matters most when the FIFO holds all sixteen entries. The bench fills the FIFO with two all-channel transfers. It then starts a third and reads on every one of the eight cycles in which that transfer writes. It judges the outcome by the overflow flag, which must stay low, and by the exact sequence of the sixteen entries read back afterwards. A later transfer into the still-full FIFO must set the flag and leave the contents unchanged.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;
  parameter int unsigned NUM_CH   = 8;
  parameter int unsigned SMP_W    = 18;
  parameter int unsigned BUS_W    = 16;
  parameter int unsigned FIFO_DEP = 16;
  parameter int unsigned BOARD_W  = 4;
endpackage

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq #(
  parameter int unsigned NCH = adc_mux_pkg::NUM_CH,
  parameter int unsigned DW  = adc_mux_pkg::SMP_W,
  parameter int unsigned CW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              xfer_i,
  input  logic              single_i,
  input  logic [CW-1:0]     sel_i,
  input  logic [NCH*DW-1:0] chan_i,
  output logic              wr_o,
  output logic [DW-1:0]     wr_data_o
);
  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  logic          xfer_q;
  logic          busy_q, busy_d;
  logic          single_q, single_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          snap_en;
  logic          rise;
  logic [DW-1:0] snap_q [NCH];

  assign rise = xfer_i & ~xfer_q;

  always_comb begin
    busy_d   = busy_q;
    single_d = single_q;
    idx_d    = idx_q;
    snap_en  = 1'b0;
    if (clr_i) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (single_q || idx_q == LAST_CH) busy_d = 1'b0;
      else                               idx_d  = idx_q + 1'b1;
    end else if (rise) begin
      busy_d   = 1'b1;
      single_d = single_i;
      idx_d    = single_i ? sel_i : '0;
      snap_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q   <= 1'b0;
      busy_q   <= 1'b0;
      single_q <= 1'b1;
      idx_q    <= '0;
    end else begin
      xfer_q   <= xfer_i;
      busy_q   <= busy_d;
      single_q <= single_d;
      idx_q    <= idx_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_snap
    always_ff @(posedge clk) begin
      if (snap_en) snap_q[c] <= chan_i[c*DW +: DW];
    end
  end

  assign wr_o      = busy_q;
  assign wr_data_o = snap_q[idx_q];
endmodule

// File: rtl/adc_img_fifo.sv
module adc_img_fifo #(
  parameter int unsigned DW    = adc_mux_pkg::SMP_W,
  parameter int unsigned DEPTH = adc_mux_pkg::FIFO_DEP,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CNTW  = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_i,
  output logic [DW-1:0]   head_o,
  output logic [CNTW-1:0] cnt_o,
  output logic            ovf_o,
  output logic            udf_o
);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [PW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            ovf_q, ovf_d, udf_q, udf_d;
  logic            empty, full, push, pop;
  logic [DW-1:0]   mem_q [DEPTH];

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL_CNT);
  assign pop   = rd_i & ~empty;
  assign push  = wr_i & (~full | pop);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    udf_d  = udf_q;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
      udf_d  = 1'b0;
    end else begin
      if (push) wptr_d = wptr_q + 1'b1;
      if (pop)  rptr_d = rptr_q + 1'b1;
      cnt_d = cnt_q + CNTW'(push) - CNTW'(pop);
      if (wr_i && full && !pop) ovf_d = 1'b1;
      if (rd_i && empty)        udf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      udf_q  <= udf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr_i) mem_q[wptr_q] <= wr_data_i;
  end

  assign head_o = empty ? '0 : mem_q[rptr_q];
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign udf_o  = udf_q;
endmodule

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
  parameter int unsigned DW  = adc_mux_pkg::SMP_W,
  parameter int unsigned OW  = adc_mux_pkg::BUS_W,
  parameter int unsigned CW  = $clog2(adc_mux_pkg::NUM_CH),
  parameter int unsigned IDW = adc_mux_pkg::BOARD_W,
  parameter int unsigned AW  = CW + IDW
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [IDW-1:0] id_i,
  input  logic           rd_i,
  input  logic           low_sel_i,
  input  logic [DW-1:0]  head_i,
  output logic           hit_o,
  output logic           rd_req_o,
  output logic [CW-1:0]  chan_o,
  output logic [OW-1:0]  data_o
);
  logic [OW-1:0] win;

  assign hit_o    = (addr_i[CW +: IDW] == id_i);
  assign rd_req_o = rd_i & hit_o;
  assign chan_o   = addr_i[CW-1:0];

  if (DW > OW) begin : g_window
    assign win = low_sel_i ? head_i[OW-1:0] : head_i[DW-1 -: OW];
  end else begin : g_pass
    logic unused_sel;
    assign unused_sel = low_sel_i;
    assign win = OW'(head_i);
  end

  assign data_o = hit_o ? win : '0;
endmodule

// File: rtl/adc_readout_mux.sv
module adc_readout_mux #(
  parameter int unsigned NCH   = adc_mux_pkg::NUM_CH,
  parameter int unsigned DW    = adc_mux_pkg::SMP_W,
  parameter int unsigned OW    = adc_mux_pkg::BUS_W,
  parameter int unsigned DEPTH = adc_mux_pkg::FIFO_DEP,
  parameter int unsigned IDW   = adc_mux_pkg::BOARD_W,
  parameter int unsigned CW    = $clog2(NCH),
  parameter int unsigned AW    = CW + IDW,
  parameter int unsigned CNTW  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] adc_data_i,
  input  logic              xfer_i,
  input  logic              single_mode_i,
  input  logic              low_sel_i,
  input  logic              fifo_clr_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [IDW-1:0]    board_id_i,
  input  logic              bus_rd_i,
  output logic [OW-1:0]     bus_data_o,
  output logic              bus_oe_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic [1:0]      rst_sync_q;
  logic            core_rst_n;
  logic            wr_en;
  logic [DW-1:0]   wr_data;
  logic [DW-1:0]   head;
  logic            rd_req;
  logic [CW-1:0]   chan_sel;
  logic [CNTW-1:0] fifo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  adc_xfer_seq #(.NCH(NCH), .DW(DW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr_i    (fifo_clr_i),
    .xfer_i   (xfer_i),
    .single_i (single_mode_i),
    .sel_i    (chan_sel),
    .chan_i   (adc_data_i),
    .wr_o     (wr_en),
    .wr_data_o(wr_data)
  );

  adc_img_fifo #(.DW(DW), .DEPTH(DEPTH), .CNTW(CNTW)) u_fifo (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr_i    (fifo_clr_i),
    .wr_i     (wr_en),
    .wr_data_i(wr_data),
    .rd_i     (rd_req),
    .head_o   (head),
    .cnt_o    (fifo_cnt),
    .ovf_o    (overflow_o),
    .udf_o    (underflow_o)
  );

  adc_bus_port #(.DW(DW), .OW(OW), .CW(CW), .IDW(IDW), .AW(AW)) u_port (
    .addr_i   (bus_addr_i),
    .id_i     (board_id_i),
    .rd_i     (bus_rd_i),
    .low_sel_i(low_sel_i),
    .head_i   (head),
    .hit_o    (bus_oe_o),
    .rd_req_o (rd_req),
    .chan_o   (chan_sel),
    .data_o   (bus_data_o)
  );
endmodule

// File: rtl/adc_readout_mux_chk.sv
module adc_readout_mux_chk #(
  parameter int unsigned OW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNTW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fifo_clr_i,
  input logic            bus_rd_i,
  input logic [OW-1:0]   bus_data_o,
  input logic            bus_oe_o,
  input logic            overflow_o,
  input logic            underflow_o,
  input logic [CNTW-1:0] fifo_cnt
);
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> bus_data_o == '0);                                  // R3
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_oe_o && fifo_cnt == '0) |-> bus_data_o == '0);   // R5
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !fifo_clr_i) |=> underflow_o);                    // R5
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !fifo_clr_i) |=> overflow_o);                      // R6
  AST_OVERFLOW_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> $past(fifo_cnt) == CNTW'(DEPTH));           // R6
  AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr_i |=> (fifo_cnt == '0 && !overflow_o && !underflow_o));  // R7
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNTW'(DEPTH));                                        // R9
endmodule

bind adc_readout_mux adc_readout_mux_chk #(.OW(OW), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_clr_i (fifo_clr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_data_o (bus_data_o),
  .bus_oe_o   (bus_oe_o),
  .overflow_o (overflow_o),
  .underflow_o(underflow_o),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/adc_readout_mux_bench.sv
`timescale 1ns/1ps
module adc_readout_mux_bench;
  localparam logic [3:0] ID = 4'hA;
  // {channel[2:0], low_sel, sample[17:0], expected bus word[15:0]}
  localparam int NV = 6;
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 1'b0, 18'h3FFFF, 16'hFFFF},
    {3'd3, 1'b0, 18'h20001, 16'h8000},
    {3'd5, 1'b1, 18'h20001, 16'h0001},
    {3'd7, 1'b1, 18'h1ABCD, 16'hABCD},
    {3'd2, 1'b0, 18'h1ABCD, 16'h6AF3},
    {3'd6, 1'b0, 18'h00003, 16'h0000}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [143:0] adc_data;
  logic         xfer, single_mode, low_sel, fifo_clr, bus_rd;
  logic [6:0]   bus_addr;
  logic [15:0]  bus_data;
  logic         bus_oe, overflow, underflow;
  int           n_tests = 0;
  int           n_fail  = 0;

  always #5 clk = ~clk;

  adc_readout_mux u_adc_readout_mux (
    .clk(clk), .rst_n(rst_n), .adc_data_i(adc_data), .xfer_i(xfer),
    .single_mode_i(single_mode), .low_sel_i(low_sel), .fifo_clr_i(fifo_clr),
    .bus_addr_i(bus_addr), .board_id_i(ID), .bus_rd_i(bus_rd),
    .bus_data_o(bus_data), .bus_oe_o(bus_oe), .overflow_o(overflow),
    .underflow_o(underflow));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all(input logic [17:0] base);
    for (int i = 0; i < 8; i++) adc_data[i*18 +: 18] = base + 18'(i);
  endtask

  // one addressed read, called right after a falling edge
  task automatic rd_chk(input logic [15:0] exp, input string tag);
    bus_rd = 1'b1;
    #1;
    chk({tag, " oe"}, 32'(bus_oe), 32'd1);
    chk(tag, 32'(bus_data), 32'(exp));
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_xfer(input int hold);
    xfer = 1'b1;
    cyc(hold);
    xfer = 1'b0;
  endtask

  task automatic pulse_clr();
    fifo_clr = 1'b1;
    cyc(1);
    fifo_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; xfer = 0; single_mode = 1; low_sel = 0; fifo_clr = 0;
    bus_rd = 0; bus_addr = 7'h00; adc_data = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R8 / R3: reset state, board not addressed
    #1;
    chk("R8 oe unaddressed", 32'(bus_oe), 0);
    chk("R8 data unaddressed", 32'(bus_data), 0);
    chk("R8 overflow", 32'(overflow), 0);
    chk("R8 underflow", 32'(underflow), 0);
    bus_addr = {ID, 3'd5};
    #1;
    chk("R3 oe addressed", 32'(bus_oe), 1);
    chk("R8 empty data", 32'(bus_data), 0);
    cyc(1);

    // R2 / R4: single-channel vectors
    for (int v = 0; v < NV; v++) begin
      logic [2:0] ch;
      ch = VEC[v][37:35];
      set_all(18'h0F0F0);
      adc_data[ch*18 +: 18] = VEC[v][33:16];
      single_mode = 1'b1;
      low_sel = VEC[v][34];
      bus_addr = {ID, ch};
      pulse_xfer(1);
      cyc(3);
      bus_addr = {ID, ~ch};
      rd_chk(VEC[v][15:0], "R2 R4 single channel word");
    end
    chk("R5 no underflow yet", 32'(underflow), 0);

    // R1 / R3: all-channels order, level held, address bits [2:0] ignored
    single_mode = 1'b0; low_sel = 1'b1;
    for (int i = 0; i < 8; i++) adc_data[i*18 +: 18] = 18'(16'h1111 * (i + 1));
    pulse_xfer(5);
    cyc(10);
    for (int i = 0; i < 4; i++) begin
      bus_addr = {ID, 3'(i * 3 + 1)};
      rd_chk(16'(16'h1111 * (i + 1)), "R1 channel order");
    end
    bus_addr = {4'h5, 3'd0};
    bus_rd = 1'b1;
    #1;
    chk("R3 oe on mismatch", 32'(bus_oe), 0);
    chk("R3 data on mismatch", 32'(bus_data), 0);
    cyc(1);
    bus_rd = 1'b0;
    for (int i = 4; i < 8; i++) begin
      bus_addr = {ID, 3'(7 - i)};
      rd_chk(16'(16'h1111 * (i + 1)), "R1 R3 order after unaddressed read");
    end
    rd_chk(16'h0000, "R1 R5 no extra entries, empty read");
    chk("R5 underflow set", 32'(underflow), 1);
    single_mode = 1'b1;
    set_all(18'h00777);
    bus_addr = {ID, 3'd2};
    pulse_xfer(1);
    cyc(3);
    rd_chk(16'h0779, "R2 after underflow");
    chk("R5 underflow sticky", 32'(underflow), 1);
    pulse_clr();
    chk("R7 underflow cleared", 32'(underflow), 0);

    // R6 / R9: fill, simultaneous write and read while full, overflow
    single_mode = 1'b0; low_sel = 1'b1; bus_addr = {ID, 3'd0};
    set_all(18'h01000); pulse_xfer(1); cyc(10);
    set_all(18'h02000); pulse_xfer(1); cyc(10);
    chk("R9 sixteen held without overflow", 32'(overflow), 0);
    set_all(18'h03000);
    pulse_xfer(1);
    for (int i = 0; i < 8; i++) rd_chk(16'(16'h1000 + i), "R6 read during writes while full");
    cyc(2);
    chk("R6 no overflow on write with pop", 32'(overflow), 0);
    set_all(18'h04000); pulse_xfer(1); cyc(10);
    chk("R6 overflow on full", 32'(overflow), 1);
    for (int i = 0; i < 8; i++) rd_chk(16'(16'h2000 + i), "R9 order older half");
    for (int i = 0; i < 8; i++) rd_chk(16'(16'h3000 + i), "R6 R9 order newer half, dropped absent");
    rd_chk(16'h0000, "R6 dropped writes not stored");
    chk("R6 overflow sticky", 32'(overflow), 1);

    // R7: clear aborts an in-flight transfer
    pulse_clr();
    chk("R7 overflow cleared", 32'(overflow), 0);
    set_all(18'h05000);
    pulse_xfer(1);
    pulse_clr();
    cyc(10);
    rd_chk(16'h0000, "R7 transfer abandoned by clear");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule